// File: doc/BRIEF.md
# Inbound DMA Address Window Mapper

This block sits in the path of addresses that bus masters on a PCI bus put out, and turns each one into a local memory address through three inbound windows. Each window holds a 64-bit attribute word and a 64-bit local base. A 32-bit register port programs both, one half at a time, and reads them back. Every window covers PCI addresses from zero up to its decoded size. A hit returns the window's local base plus the PCI address.

When no enabled window covers the address, the block reports a miss and hands the address on unchanged to the default bus-memory path. The translation is purely combinational: the PCI address in a cycle produces its result in that same cycle. The register file takes effect on the clock edge that follows a write. The block does not perform the memory accesses or the bus handshakes.

Top module: `iwm_inbound_map`

## Requirements
- R1: After a synchronous reset, both wide attribute words read 0xFFFFFFFF in their upper half and 0 in their lower half. The narrow attribute of window 1 reads 0, every local base reads 0, and no address hits.
- R2: Register byte offsets. Window 0: attribute low 0x98, attribute high 0xF8, base low 0x9C, base high 0xA0. Window 1: attribute 0xA4, base low 0xA8, base high 0xAC. Window 2: attribute low 0xB0, attribute high 0xFC, base low 0xB4, base high 0xB8.
- R3: A write to one 32-bit half replaces only that half and leaves the other half as it was. The value is visible on the read port from the next cycle.
- R4: A read from an offset not listed in R2 returns 0. A write to such an offset changes no register and no translation result.
- R5: Bit 0 of the attribute word enables its window. A window whose bit 0 is clear never hits.
- R6: The window size is the 64-bit two's complement of the attribute word after its low three bits are cleared. An address hits when it is unsigned-less-than that size. A decoded size of zero hits nothing.
- R7: Window 1's 32-bit attribute is zero-extended to 64 bits before the size is decoded.
- R8: On a hit, xlat_hit is 1, xlat_win is the window index, and xlat_addr is the local base plus the PCI address modulo 2^64.
- R9: When several enabled windows cover the address, the lowest window index is used.
- R10: On a miss, xlat_hit is 0, xlat_win is 0, and xlat_addr equals pci_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 8 | Byte offset of the register write |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 8 | Byte offset of the register read |
| reg_rd_data | output | 32 | Read data, combinational from reg_rd_addr |
| pci_addr | input | 64 | Address issued by a PCI bus master |
| xlat_hit | output | 1 | An enabled window covers pci_addr |
| xlat_win | output | 2 | Index of the window used |
| xlat_addr | output | 64 | Translated local address, or pci_addr on a miss |

## Verification
The hardest case to reach from the ports is an overlap, where a narrow low window sits inside a wider one. Only then does the index priority decide the result. The stimulus enables window 1 with a 32-bit attribute that, once zero-extended, decodes to a span of nearly 2^64. It then re-enables window 0 with a 256 MiB span. Addresses are then placed inside both windows and just beyond the smaller one. A second hard case is a span of exactly zero and a span of eight bytes with a base near the top of the address space. This is reached by writing the two halves of window 2's attribute separately, and it exercises the wrap of the sum as well.

// File: rtl/iwm_pkg.sv
// Package: shared widths and the register layout of the inbound window mapper.
// Assumes exactly three windows; the offsets are software-visible and fixed.
package iwm_pkg;
    localparam int NUM_WIN = 3;
    localparam int WIN_W   = $clog2(NUM_WIN);
    localparam int ADDR_W  = 64;
    localparam int DATA_W  = 32;
    localparam int REG_AW  = 8;
    localparam logic [ADDR_W-1:0] ATTR_RST = 64'hFFFF_FFFF_0000_0000;
    localparam logic [ADDR_W-1:0] SIZE_MASK = ~64'h7;

    function automatic logic [REG_AW-1:0] attr_lo_off(input int i);
        case (i)
            0:       return 8'h98;
            1:       return 8'hA4;
            default: return 8'hB0;
        endcase
    endfunction

    function automatic logic [REG_AW-1:0] attr_hi_off(input int i);
        case (i)
            0:       return 8'hF8;
            2:       return 8'hFC;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [REG_AW-1:0] base_lo_off(input int i);
        case (i)
            0:       return 8'h9C;
            1:       return 8'hA8;
            default: return 8'hB4;
        endcase
    endfunction

    function automatic logic [REG_AW-1:0] base_hi_off(input int i);
        case (i)
            0:       return 8'hA0;
            1:       return 8'hAC;
            default: return 8'hB8;
        endcase
    endfunction

    function automatic bit wide_attr(input int i);
        return i != 1;
    endfunction

    // True when an offset names one of the window registers.
    function automatic bit is_reg_offset(input logic [REG_AW-1:0] a);
        for (int i = 0; i < NUM_WIN; i++) begin
            if (a == attr_lo_off(i) || a == base_lo_off(i) || a == base_hi_off(i))
                return 1'b1;
            if (wide_attr(i) && a == attr_hi_off(i))
                return 1'b1;
        end
        return 1'b0;
    endfunction
endpackage

// File: rtl/iwm_win_regs.sv
// Register storage for one window: attribute word and local base, split into
// 32-bit halves. WIDE_ATTR=0 gives a 32-bit attribute whose upper half is zero.
// Assumes word-aligned byte offsets that are unique across the whole block.
module iwm_win_regs
    import iwm_pkg::*;
#(
    parameter logic [REG_AW-1:0] OFF_ATTR_LO = 8'h98,
    parameter logic [REG_AW-1:0] OFF_ATTR_HI = 8'hF8,
    parameter logic [REG_AW-1:0] OFF_BASE_LO = 8'h9C,
    parameter logic [REG_AW-1:0] OFF_BASE_HI = 8'hA0,
    parameter bit                WIDE_ATTR   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word,
    output logic [ADDR_W-1:0] attr,
    output logic [ADDR_W-1:0] base
);
    logic [DATA_W-1:0] attr_lo_q, attr_hi_q, base_lo_q, base_hi_q;

    // Lower attribute half and both base halves: reset, then replace on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            attr_lo_q <= ATTR_RST[DATA_W-1:0];
            base_lo_q <= '0;
            base_hi_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == OFF_ATTR_LO) attr_lo_q <= wr_data;
            if (wr_addr == OFF_BASE_LO) base_lo_q <= wr_data;
            if (wr_addr == OFF_BASE_HI) base_hi_q <= wr_data;
        end
    end

    generate
        if (WIDE_ATTR) begin : g_wide
            // Upper attribute half: resets to all ones, replaced on write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    attr_hi_q <= ATTR_RST[ADDR_W-1:DATA_W];
                else if (wr_en && wr_addr == OFF_ATTR_HI)
                    attr_hi_q <= wr_data;
            end
        end else begin : g_narrow
            assign attr_hi_q = '0;
        end
    endgenerate

    assign attr = {attr_hi_q, attr_lo_q};
    assign base = {base_hi_q, base_lo_q};

    // Readback: the addressed half, or zero when no register here matches.
    always_comb begin
        rd_word = '0;
        if (rd_addr == OFF_ATTR_LO)                    rd_word = attr_lo_q;
        else if (WIDE_ATTR && rd_addr == OFF_ATTR_HI)  rd_word = attr_hi_q;
        else if (rd_addr == OFF_BASE_LO)               rd_word = base_lo_q;
        else if (rd_addr == OFF_BASE_HI)               rd_word = base_hi_q;
    end
endmodule

// File: rtl/iwm_win_match.sv
// Size decode and hit test for one window, plus its translated address.
// Assumes the window starts at PCI address zero; purely combinational.
module iwm_win_match
    import iwm_pkg::*;
(
    input  logic [ADDR_W-1:0] attr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] pci_addr,
    output logic              hit,
    output logic [ADDR_W-1:0] xlat
);
    logic [ADDR_W-1:0] span;

    // Span is the two's complement of the masked attribute; zero means empty.
    always_comb begin
        span = ~(attr & SIZE_MASK) + {{(ADDR_W-1){1'b0}}, 1'b1};
        hit  = attr[0] && (pci_addr < span);
        xlat = base + pci_addr;
    end
endmodule

// File: rtl/iwm_inbound_map.sv
// Top of the inbound window mapper: register port, three windows and a
// lowest-index-first select. A miss passes pci_addr through unchanged.
// Assumes the register port and pci_addr are in the clk domain.
module iwm_inbound_map
    import iwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [7:0]        reg_wr_addr,
    input  logic [31:0]       reg_wr_data,
    input  logic [7:0]        reg_rd_addr,
    output logic [31:0]       reg_rd_data,
    input  logic [63:0]       pci_addr,
    output logic              xlat_hit,
    output logic [1:0]        xlat_win,
    output logic [63:0]       xlat_addr
);
    logic [DATA_W-1:0] win_rd   [NUM_WIN];
    logic [ADDR_W-1:0] win_attr [NUM_WIN];
    logic [ADDR_W-1:0] win_base [NUM_WIN];
    logic [ADDR_W-1:0] win_xlat [NUM_WIN];
    logic [NUM_WIN-1:0] win_hit;

    generate
        for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
            iwm_win_regs #(
                .OFF_ATTR_LO (attr_lo_off(i)),
                .OFF_ATTR_HI (attr_hi_off(i)),
                .OFF_BASE_LO (base_lo_off(i)),
                .OFF_BASE_HI (base_hi_off(i)),
                .WIDE_ATTR   (wide_attr(i))
            ) u_regs (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (reg_wr_en),
                .wr_addr (reg_wr_addr),
                .wr_data (reg_wr_data),
                .rd_addr (reg_rd_addr),
                .rd_word (win_rd[i]),
                .attr    (win_attr[i]),
                .base    (win_base[i])
            );

            iwm_win_match u_match (
                .attr     (win_attr[i]),
                .base     (win_base[i]),
                .pci_addr (pci_addr),
                .hit      (win_hit[i]),
                .xlat     (win_xlat[i])
            );
        end
    endgenerate

    // Read mux: offsets are unique, so OR-ing the per-window words is exact.
    always_comb begin
        reg_rd_data = '0;
        for (int i = 0; i < NUM_WIN; i++)
            reg_rd_data = reg_rd_data | win_rd[i];
    end

    // Select: walk from the highest index down so the lowest hit wins.
    always_comb begin
        xlat_hit  = 1'b0;
        xlat_win  = '0;
        xlat_addr = pci_addr;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (win_hit[i]) begin
                xlat_hit  = 1'b1;
                xlat_win  = WIN_W'(i);
                xlat_addr = win_xlat[i];
            end
        end
    end
endmodule

// File: rtl/iwm_inbound_map_chk.sv
// Checker for the inbound window mapper, attached by bind. Observes ports only.
module iwm_inbound_map_chk
    import iwm_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr_en,
    input logic [7:0]  reg_wr_addr,
    input logic [31:0] reg_wr_data,
    input logic [7:0]  reg_rd_addr,
    input logic [31:0] reg_rd_data,
    input logic [63:0] pci_addr,
    input logic        xlat_hit,
    input logic [1:0]  xlat_win,
    input logic [63:0] xlat_addr
);
    // R1: straight after reset nothing is enabled, so nothing may hit.
    a_r1_no_hit_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !xlat_hit);

    // R1: the upper attribute half of window 0 resets to all ones.
    a_r1_attr_hi_reset: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && reg_rd_addr == 8'hF8) |-> reg_rd_data == 32'hFFFF_FFFF);

    // R3: a written register reads back its data on the next cycle.
    a_r3_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(reg_wr_en) && $past(reg_wr_addr) == reg_rd_addr
         && is_reg_offset(reg_rd_addr)) |-> reg_rd_data == $past(reg_wr_data));

    // R4: offsets outside the map read zero.
    a_r4_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !is_reg_offset(reg_rd_addr) |-> reg_rd_data == 32'h0);

    // R9: a hit always names an existing window.
    a_r9_win_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_hit |-> xlat_win < 2'(NUM_WIN));

    // R10: a miss passes the address through with index zero.
    a_r10_miss_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        !xlat_hit |-> (xlat_addr == pci_addr && xlat_win == 2'd0));
endmodule

bind iwm_inbound_map iwm_inbound_map_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_addr (reg_wr_addr),
    .reg_wr_data (reg_wr_data),
    .reg_rd_addr (reg_rd_addr),
    .reg_rd_data (reg_rd_data),
    .pci_addr    (pci_addr),
    .xlat_hit    (xlat_hit),
    .xlat_win    (xlat_win),
    .xlat_addr   (xlat_addr)
);

// File: tb/iwm_inbound_map_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every falling edge, plus
// directed checks with hand-computed values for each requirement.
module iwm_inbound_map_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_wr_addr = '0;
    logic [31:0] reg_wr_data = '0;
    logic [7:0]  reg_rd_addr = '0;
    logic [31:0] reg_rd_data;
    logic [63:0] pci_addr = '0;
    logic        xlat_hit;
    logic [1:0]  xlat_win;
    logic [63:0] xlat_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference state: attribute and base per window, 64 bits each.
    logic [63:0] m_attr [3];
    logic [63:0] m_base [3];

    always #2.5 clk = ~clk;

    iwm_inbound_map u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .pci_addr(pci_addr), .xlat_hit(xlat_hit), .xlat_win(xlat_win), .xlat_addr(xlat_addr)
    );

    // Model register update on the rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_attr[0] = 64'hFFFF_FFFF_0000_0000;
            m_attr[1] = 64'h0;
            m_attr[2] = 64'hFFFF_FFFF_0000_0000;
            for (int k = 0; k < 3; k++) m_base[k] = 64'h0;
        end else if (reg_wr_en) begin
            case (reg_wr_addr)
                8'h98: m_attr[0][31:0]  = reg_wr_data;
                8'hF8: m_attr[0][63:32] = reg_wr_data;
                8'h9C: m_base[0][31:0]  = reg_wr_data;
                8'hA0: m_base[0][63:32] = reg_wr_data;
                8'hA4: m_attr[1]        = {32'h0, reg_wr_data};
                8'hA8: m_base[1][31:0]  = reg_wr_data;
                8'hAC: m_base[1][63:32] = reg_wr_data;
                8'hB0: m_attr[2][31:0]  = reg_wr_data;
                8'hFC: m_attr[2][63:32] = reg_wr_data;
                8'hB4: m_base[2][31:0]  = reg_wr_data;
                8'hB8: m_base[2][63:32] = reg_wr_data;
                default: ;
            endcase
        end
    end

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h98: return m_attr[0][31:0];
            8'hF8: return m_attr[0][63:32];
            8'h9C: return m_base[0][31:0];
            8'hA0: return m_base[0][63:32];
            8'hA4: return m_attr[1][31:0];
            8'hA8: return m_base[1][31:0];
            8'hAC: return m_base[1][63:32];
            8'hB0: return m_attr[2][31:0];
            8'hFC: return m_attr[2][63:32];
            8'hB4: return m_base[2][31:0];
            8'hB8: return m_base[2][63:32];
            default: return 32'h0;
        endcase
    endfunction

    // Expected translation as {hit, win, addr}.
    function automatic logic [66:0] m_xlat(input logic [63:0] a);
        for (int k = 0; k < 3; k++) begin
            logic [63:0] sz;
            sz = -(m_attr[k] & ~64'h7);
            if (m_attr[k][0] && a < sz)
                return {1'b1, 2'(k), m_base[k] + a};
        end
        return {1'b0, 2'd0, a};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Continuous comparison against the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [66:0] e;
            e = m_xlat(pci_addr);
            chk("R3 model readback", 64'(reg_rd_data), 64'(m_read(reg_rd_addr)));
            chk("R8 model hit", 64'(xlat_hit), 64'(e[66]));
            chk("R9 model window", 64'(xlat_win), 64'(e[65:64]));
            chk("R10 model address", xlat_addr, e[63:0]);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(posedge clk); #1;
        reg_wr_en = 1'b0;
    endtask

    task automatic look(input logic [7:0] a, input logic [63:0] p);
        @(posedge clk); #1;
        reg_rd_addr = a; pci_addr = p;
        @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #500000;
        checks++; errors++;
        $display("FAIL watchdog: actual hung, expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 / R2: reset values at their offsets.
        look(8'h98, 64'h0); chk("R1 attr0 lo", 64'(reg_rd_data), 64'h0);
        chk("R1 no hit after reset", 64'(xlat_hit), 64'h0);
        look(8'hF8, 64'h0); chk("R1 R2 attr0 hi", 64'(reg_rd_data), 64'hFFFF_FFFF);
        look(8'hFC, 64'h0); chk("R1 R2 attr2 hi", 64'(reg_rd_data), 64'hFFFF_FFFF);
        look(8'hA4, 64'h0); chk("R1 R2 attr1", 64'(reg_rd_data), 64'h0);
        look(8'hB8, 64'h0); chk("R1 R2 base2 hi", 64'(reg_rd_data), 64'h0);

        // R3 / R6 / R8: window 0, 256 MiB, base 0x1_1000_0000.
        wr(8'h9C, 32'h1000_0000);
        wr(8'hA0, 32'h0000_0001);
        wr(8'h98, 32'hF000_0001);
        look(8'hF8, 64'h0FFF_FFFF);
        chk("R3 other half kept", 64'(reg_rd_data), 64'hFFFF_FFFF);
        chk("R6 R8 hit at top", 64'(xlat_hit), 64'h1);
        chk("R8 translated", xlat_addr, 64'h1_1FFF_FFFF);
        look(8'h98, 64'h1000_0000);
        chk("R3 readback lo", 64'(reg_rd_data), 64'hF000_0001);
        chk("R10 miss past size", 64'(xlat_hit), 64'h0);
        chk("R10 passthrough", xlat_addr, 64'h1000_0000);

        // R6: low attribute bits 1..2 do not change the size.
        wr(8'h98, 32'hF000_0007);
        look(8'h98, 64'h0FFF_FFFF); chk("R6 low bits masked", 64'(xlat_hit), 64'h1);

        // R5: enable bit cleared.
        wr(8'h98, 32'hF000_0000);
        look(8'h98, 64'h10); chk("R5 disabled no hit", 64'(xlat_hit), 64'h0);

        // R7: window 1 attribute zero-extended, span nearly 2^64.
        wr(8'hA8, 32'h2000_0000);
        wr(8'hA4, 32'hFFFF_0001);
        look(8'hA4, 64'h1_0000_0000);
        chk("R7 attr1 readback", 64'(reg_rd_data), 64'hFFFF_0001);
        chk("R7 hit high addr", 64'(xlat_hit), 64'h1);
        chk("R7 window 1", 64'(xlat_win), 64'h1);
        chk("R7 R8 addr", xlat_addr, 64'h1_2000_0000);

        // R9: overlap, lowest index wins.
        wr(8'h98, 32'hF000_0001);
        look(8'h98, 64'h1234);
        chk("R9 window 0 wins", 64'(xlat_win), 64'h0);
        chk("R9 addr via window 0", xlat_addr, 64'h1_1000_1234);
        look(8'h98, 64'h2000_0000);
        chk("R9 beyond window 0", 64'(xlat_win), 64'h1);
        chk("R9 addr via window 1", xlat_addr, 64'h4000_0000);

        // R6: zero span hits nothing; eight-byte span; R8 wrap.
        wr(8'hA4, 32'h0);
        wr(8'h98, 32'h0);
        wr(8'hFC, 32'h0);
        wr(8'hB0, 32'h1);
        look(8'hB0, 64'h0); chk("R6 zero span", 64'(xlat_hit), 64'h0);
        wr(8'hFC, 32'hFFFF_FFFF);
        wr(8'hB0, 32'hFFFF_FFF9);
        wr(8'hB4, 32'hFFFF_FFFC);
        wr(8'hB8, 32'hFFFF_FFFF);
        look(8'hB0, 64'h7);
        chk("R6 last byte hits", 64'(xlat_hit), 64'h1);
        chk("R8 window 2", 64'(xlat_win), 64'h2);
        chk("R8 wrap", xlat_addr, 64'h3);
        look(8'hB0, 64'h8); chk("R6 first miss", 64'(xlat_hit), 64'h0);

        // R4: unmapped offsets.
        wr(8'h90, 32'hDEAD_BEEF);
        look(8'h90, 64'h7);
        chk("R4 unmapped reads zero", 64'(reg_rd_data), 64'h0);
        chk("R4 translation unchanged", xlat_addr, 64'h3);
        look(8'hE0, 64'h7); chk("R4 other offset zero", 64'(reg_rd_data), 64'h0);

        finish_run();
    end
endmodule